// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects five interrupt sources for a small 8-bit CPU core: two external pins (active low), two timer overflow flags and one serial port event. It raises a single request toward the core together with a fixed 16-bit vector address. It waits for the core's acknowledge, and then it records which priority level is being serviced. The core reports the end of each handler with a return-from-interrupt pulse, and the controller then releases the active level.

Software writes two byte registers over a simple write port. The enable byte holds a global gate and one enable per source. The priority byte holds one level bit per source. A high-level request may interrupt a low-level handler. A request of the same or a lower level waits for the return pulse. Each external pin can count as a level (low input) or as a falling edge, and an edge is held in a flag until its vector is taken. The timers, the serial port and the core are outside the block. Their flags arrive as inputs, and the controller sends back a one-cycle clear to the timer it services.

The sequencer has two states. In ARB_IDLE it arbitrates each cycle. The transition "grant" moves it to ARB_HOLD when some eligible request exists, and the chosen vector is latched on that transition. In ARB_HOLD the request stays asserted. The transition "take" returns it to ARB_IDLE when the core acknowledges, and that transition marks the source's level as active. A return pulse outside "take" clears the high active level if it is set, and otherwise clears the low one.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the request is low, the vector reads 0x0000, no timer clear is driven, and both registers read zero, so no source can request until software enables it.
- R2: Bit 7 of the enable byte (`reg_sel`=0) is a global gate. While it is 0, no request is raised whatever the other bits hold.
- R3: Enable bits 0..4 belong to external 0, timer 0, external 1, timer 1 and serial, in that order. A source whose bit is 0 never raises a request.
- R4: The vector is 0x0003 + 8 x index for source index 0..4, which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R5: Among pending requests of one level, the lowest index wins.
- R6: Priority bits 0..4 (`reg_sel`=1) use the same source order, and 1 means high. A pending high request wins over any low one, whatever the index order.
- R7: While a low-level handler is active and no high one is, a high-level request is raised.
- R8: A request whose level is equal to or lower than an active level is held back. Each return pulse releases the high active level first, and the low one only after that.
- R9: When a source's type input is 1, a falling edge on its pin sets a flag that stays until its vector is acknowledged. When the type input is 0, the source requests for as long as the pin is low.
- R10: `tmr_ovf_clr` bit 0 or bit 1 pulses during the acknowledge cycle only, and only when the granted source is timer 0 or timer 1 respectively.
- R11: The serial source requests when the transmit-done input or the receive-done input is high.
- R12: Once raised, the request and its vector hold steady until the acknowledge, and the request drops in the cycle after it.

Ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable byte, 1 selects the priority byte |
| reg_wdata | input | 8 | Register write data |
| ext_n | input | 2 | External interrupt pins, active low |
| ext_edge | input | 2 | Per-pin type: 1 for falling edge, 0 for low level |
| tmr_ovf | input | 2 | Timer 0 / timer 1 overflow flags |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| ser_rx_done | input | 1 | Serial receive-done flag |
| cpu_ack | input | 1 | Core accepts the pending vector |
| cpu_reti | input | 1 | Core leaves a handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 16 | Vector address of the granted source |
| tmr_ovf_clr | output | 2 | One-cycle clear to the serviced timer's flag |

## Verification
The bench raises several sources in the same cycle. A design with a wrong order, or one that ignores the level bits, would grant the wrong vector first. It opens a low-level handler and then shows that an equal-level request stays silent while a high-level one is still granted. A broken nesting check would either refuse to pre-empt or allow a same-level interrupt to nest. It sends single-cycle pulses on edge-mode pins and holds level-mode pins low across a return, to catch a flag that is never cleared (endless re-request) or a level source that is wrongly remembered. It also checks that the timer clear reaches the right timer and does not fire for serial or external grants.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 5;
    localparam int IDX_W   = $clog2(NUM_SRC);

    typedef logic [IDX_W-1:0] src_idx_t;

    typedef enum logic {
        ARB_IDLE,
        ARB_HOLD
    } arb_state_t;

    localparam src_idx_t IDX_EXT0 = src_idx_t'(0);
    localparam src_idx_t IDX_TMR0 = src_idx_t'(1);
    localparam src_idx_t IDX_EXT1 = src_idx_t'(2);
    localparam src_idx_t IDX_TMR1 = src_idx_t'(3);
    localparam src_idx_t IDX_SER  = src_idx_t'(4);
endpackage

// File: rtl/irq_ext_flag.sv
module irq_ext_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic served,
    output logic req
);
    logic pin_prev;
    logic latched;
    logic fall;

    assign fall = pin_prev & ~pin_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_prev <= 1'b1;
            latched  <= 1'b0;
        end else begin
            pin_prev <= pin_n;
            if (!edge_mode)
                latched <= 1'b0;
            else if (fall)
                latched <= 1'b1;
            else if (served)
                latched <= 1'b0;
        end
    end

    assign req = edge_mode ? latched : ~pin_n;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] src_en,
    input  logic         gate,
    input  logic [N-1:0] src_hi,
    input  logic         act_hi,
    input  logic         act_lo,
    output logic         win_valid,
    output logic         win_hi,
    output src_idx_t     win_idx
);
    logic [N-1:0] hi_mask;
    logic [N-1:0] lo_mask;
    logic [N-1:0] pick;

    always_comb begin
        hi_mask = pend & src_en & src_hi & {N{gate & ~act_hi}};
        lo_mask = pend & src_en & ~src_hi & {N{gate & ~act_hi & ~act_lo}};
        win_hi  = |hi_mask;
        pick    = win_hi ? hi_mask : lo_mask;
        win_valid = |pick;
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pick[i])
                win_idx = src_idx_t'(i);
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8,
    parameter int N_EXT    = 2,
    parameter int N_TMR    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [7:0]       reg_wdata,
    input  logic [N_EXT-1:0] ext_n,
    input  logic [N_EXT-1:0] ext_edge,
    input  logic [N_TMR-1:0] tmr_ovf,
    input  logic             ser_tx_done,
    input  logic             ser_rx_done,
    input  logic             cpu_ack,
    input  logic             cpu_reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector,
    output logic [N_TMR-1:0] tmr_ovf_clr
);
    localparam int GATE_BIT = 7;

    arb_state_t           state_q, state_nx;
    logic                 gate_q;
    logic [NUM_SRC-1:0]   en_q;
    logic [NUM_SRC-1:0]   hi_q;
    logic [NUM_SRC-1:0]   pend;
    logic [N_EXT-1:0]     ext_req;
    logic [N_EXT-1:0]     ext_served;
    src_idx_t             sel_q;
    logic                 sel_hi_q;
    logic [VEC_W-1:0]     vec_q;
    logic                 act_hi_q, act_lo_q;
    logic                 win_valid, win_hi;
    src_idx_t             win_idx;
    logic                 take;
    logic                 wdata_unused;

    assign wdata_unused = ^reg_wdata[6:NUM_SRC];

    // software-visible enable and priority bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            en_q   <= '0;
            hi_q   <= '0;
        end else if (reg_we) begin
            if (!reg_sel) begin
                gate_q <= reg_wdata[GATE_BIT];
                en_q   <= reg_wdata[NUM_SRC-1:0];
            end else begin
                hi_q   <= reg_wdata[NUM_SRC-1:0];
            end
        end
    end

    // external sources sit at even indices, timers at odd ones
    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        assign ext_served[k] = take && (sel_q == src_idx_t'(2 * k));
        irq_ext_flag u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[k]),
            .edge_mode (ext_edge[k]),
            .served    (ext_served[k]),
            .req       (ext_req[k])
        );
        assign pend[2 * k] = ext_req[k];
    end

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        assign pend[2 * t + 1] = tmr_ovf[t];
        assign tmr_ovf_clr[t]  = take && (sel_q == src_idx_t'(2 * t + 1));
    end

    assign pend[IDX_SER] = ser_tx_done | ser_rx_done;

    irq_pick #(.N(NUM_SRC)) u_pick (
        .pend      (pend),
        .src_en    (en_q),
        .gate      (gate_q),
        .src_hi    (hi_q),
        .act_hi    (act_hi_q),
        .act_lo    (act_lo_q),
        .win_valid (win_valid),
        .win_hi    (win_hi),
        .win_idx   (win_idx)
    );

    assign take = (state_q == ARB_HOLD) && cpu_ack;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ARB_IDLE;
        else
            state_q <= state_nx;
    end

    // next-state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ARB_IDLE: if (win_valid) state_nx = ARB_HOLD;   // grant
            ARB_HOLD: if (cpu_ack)   state_nx = ARB_IDLE;   // take
        endcase
    end

    // latched grant and active-level record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            sel_hi_q <= 1'b0;
            vec_q    <= '0;
            act_hi_q <= 1'b0;
            act_lo_q <= 1'b0;
        end else begin
            if (state_q == ARB_IDLE && win_valid) begin
                sel_q    <= win_idx;
                sel_hi_q <= win_hi;
                vec_q    <= VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP);
            end
            if (take) begin
                if (sel_hi_q) act_hi_q <= 1'b1;
                else          act_lo_q <= 1'b1;
            end else if (cpu_reti) begin
                if (act_hi_q) act_hi_q <= 1'b0;
                else          act_lo_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        irq_req    = (state_q == ARB_HOLD);
        irq_vector = vec_q;
    end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int VEC_W = 16,
    parameter int N_TMR = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic             cpu_ack,
    input logic [VEC_W-1:0] irq_vector,
    input logic [N_TMR-1:0] tmr_clr,
    input logic             gate
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !cpu_ack |=> irq_req && $stable(irq_vector)); // R12

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && cpu_ack |=> !irq_req); // R12

    AST_VEC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector[2:0] == 3'd3) && (irq_vector <= VEC_W'(16'h0023))); // R4

    AST_CLR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_clr) |-> irq_req && cpu_ack); // R10

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_clr)); // R10

    AST_GATE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(gate)); // R2
endmodule

bind irq_arbiter irq_arbiter_chk #(.VEC_W(VEC_W), .N_TMR(N_TMR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .cpu_ack    (cpu_ack),
    .irq_vector (irq_vector),
    .tmr_clr    (tmr_ovf_clr),
    .gate       (gate_q)
);

// File: tb/test_irq_arbiter.sv
`timescale 1ns/1ps
module test_irq_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  ext_edge = 2'b00;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_tx_done = 1'b0;
    logic        ser_rx_done = 1'b0;
    logic        cpu_ack = 1'b0;
    logic        cpu_reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vector;
    logic [1:0]  tmr_ovf_clr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] q_vec[$];
    logic [1:0]  q_clr[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    irq_arbiter i_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ext_n(ext_n), .ext_edge(ext_edge),
        .tmr_ovf(tmr_ovf), .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
        .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .irq_req(irq_req),
        .irq_vector(irq_vector), .tmr_ovf_clr(tmr_ovf_clr)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_grant(input logic [15:0] vec, input logic [1:0] clr, input string tag);
        q_vec.push_back(vec);
        q_clr.push_back(clr);
        q_tag.push_back(tag);
    endtask

    // monitor: pops the scoreboard on each request, answers with an acknowledge
    initial begin
        forever begin
            @(negedge clk);
            if (cpu_ack) begin
                cpu_ack = 1'b0;
            end else if (rst_n && irq_req) begin
                if (q_vec.size() == 0) begin
                    chk(1'b0, "R8", "unexpected request vector", 32'(irq_vector), 32'hFFFF);
                end else begin
                    automatic logic [15:0] ev = q_vec.pop_front();
                    automatic logic [1:0]  ec = q_clr.pop_front();
                    automatic string       et = q_tag.pop_front();
                    chk(irq_vector == ev, et, "vector", 32'(irq_vector), 32'(ev));
                    cpu_ack = 1'b1;
                    #1;
                    chk(tmr_ovf_clr == ec, "R10", "timer clear", 32'(tmr_ovf_clr), 32'(ec));
                    if (tmr_ovf_clr[0]) tmr_ovf[0] = 1'b0;
                    if (tmr_ovf_clr[1]) tmr_ovf[1] = 1'b0;
                end
            end
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reti_pulse();
        @(negedge clk);
        cpu_reti = 1'b1;
        @(negedge clk);
        cpu_reti = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (q_vec.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(q_vec.size() == 0, tag, "grant never seen, pending items", 32'(q_vec.size()), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic quiet(input int cycles, input string tag);
        bit seen = 1'b0;
        repeat (cycles) begin
            @(negedge clk);
            if (irq_req) seen = 1'b1;
        end
        chk(!seen, tag, "request while held off", 32'(seen), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq_req == 1'b0, "R1", "req after reset", 32'(irq_req), 0);
        chk(irq_vector == 16'h0000, "R1", "vector after reset", 32'(irq_vector), 0);
        chk(tmr_ovf_clr == 2'b00, "R1", "clear after reset", 32'(tmr_ovf_clr), 0);
        tmr_ovf[0] = 1'b1;
        quiet(8, "R1");
        tmr_ovf[0] = 1'b0;

        // R3: only timer 0 enabled, timer 1 raised
        wr(1'b0, 8'h82);
        tmr_ovf[1] = 1'b1;
        quiet(10, "R3");
        tmr_ovf[1] = 1'b0;

        // R2: ext0 enabled but gate closed, level mode low
        wr(1'b0, 8'h01);
        ext_n[0] = 1'b0;
        quiet(10, "R2");
        expect_grant(16'h0003, 2'b00, "R2");
        wr(1'b0, 8'h81);
        drain("R2");
        // R9 level: still low after return -> requests again
        expect_grant(16'h0003, 2'b00, "R9");
        reti_pulse();
        drain("R9");
        ext_n[0] = 1'b1;
        reti_pulse();
        quiet(6, "R9");

        // R11 transmit-done alone
        wr(1'b0, 8'h90);
        expect_grant(16'h0023, 2'b00, "R11");
        ser_tx_done = 1'b1;
        drain("R11");
        ser_tx_done = 1'b0;
        reti_pulse();

        // R5 fixed order, R4 vectors: timer 0, timer 1, serial together
        wr(1'b0, 8'h9F);
        wr(1'b1, 8'h00);
        expect_grant(16'h000B, 2'b01, "R5");
        tmr_ovf = 2'b11;
        ser_tx_done = 1'b1;
        drain("R5");
        expect_grant(16'h001B, 2'b10, "R4");
        reti_pulse();
        drain("R4");
        expect_grant(16'h0023, 2'b00, "R5");
        reti_pulse();
        drain("R5");
        ser_tx_done = 1'b0;
        reti_pulse();
        quiet(5, "R8");

        // R6 + R9 edge: pulse both pins, ext1 high level wins over ext0
        wr(1'b1, 8'h04);
        ext_edge = 2'b11;
        repeat (2) @(negedge clk);
        expect_grant(16'h0013, 2'b00, "R6");
        ext_n = 2'b00;
        @(negedge clk);
        ext_n = 2'b11;
        drain("R6");
        expect_grant(16'h0003, 2'b00, "R9");
        reti_pulse();
        drain("R9");
        reti_pulse();
        quiet(10, "R9");
        ext_edge = 2'b00;

        // R7 / R8 nesting: serial low active, timer1 high preempts, timer0 low waits
        wr(1'b0, 8'h9A);
        wr(1'b1, 8'h08);
        expect_grant(16'h0023, 2'b00, "R11");
        ser_rx_done = 1'b1;
        drain("R11");
        tmr_ovf[0] = 1'b1;
        quiet(8, "R8");
        expect_grant(16'h001B, 2'b10, "R7");
        tmr_ovf[1] = 1'b1;
        drain("R7");
        reti_pulse();
        quiet(8, "R8");
        ser_rx_done = 1'b0;
        expect_grant(16'h000B, 2'b01, "R8");
        reti_pulse();
        drain("R8");
        reti_pulse();
        quiet(6, "R12");

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule